// File: doc/BRIEF.md
# Tree Parallel Prefix Summer

This block takes eight unsigned lane values in one cycle and returns, for every lane, the sum of that lane and all lanes below it (an inclusive running total). The values travel through a balanced binary tree in two sweeps. On the way up, each internal node adds its two children's totals, passes the result to its parent and keeps the left child's total. On the way down, the root hands a zero to its left child and its kept left total to its right child. Every other internal node forwards what it received to its left child, and passes that value plus its kept left total to its right child. Each leaf adds the value it received to its own input.

Every tree level costs one register stage in each direction, so the latency is fixed at twice the tree depth. Only one input set is in flight at a time. A strobe that arrives while a set is still travelling is dropped. A strobe that arrives in the cycle the previous result is presented is taken.

Top module: `tree_prefix_sum`

## Requirements
- R1: While and right after synchronous reset (active-low `rst_n`), `out_valid` is 0 and `out_sum` is all zeros.
- R2: When `in_valid` is sampled high on a clock edge and the strobe is taken, `out_valid` goes high after the sixth rising edge counted from that edge (that edge included) and stays high for exactly one cycle.
- R3: Lane k of the input occupies `in_data[k*8 +: 8]` and lane k of the result occupies `out_sum[k*11 +: 11]`. When `out_valid` is high, result lane k equals the unsigned sum of input lanes 0 through k of the accepted set.
- R4: Results are 11 bits wide and do not overflow. With every input lane at 255, result lane k is 255*(k+1), so the top lane is 2040.
- R5: The input lanes 1,2,3,4,5,6,7,8 (lane 0 first) give the result lanes 1,3,6,10,15,21,28,36.
- R6: A strobe that arrives after a set has been taken and before that set's `out_valid` cycle is ignored. It produces no extra `out_valid` pulse and does not alter the result of the set in flight.
- R7: A strobe in the same cycle as `out_valid` is taken. Its own `out_valid` follows six edges later.
- R8: `out_sum` keeps its value in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe marking `in_data` as a new input set |
| in_data | input | 64 | Eight 8-bit unsigned lanes, lane k at bits k*8 upward |
| out_valid | output | 1 | One-cycle pulse marking `out_sum` as a new result |
| out_sum | output | 88 | Eight 11-bit inclusive running totals, lane k at bits k*11 upward |

## Verification
Two events can fall in the same cycle: presenting the result of one set and taking the strobe of the next. The bench provokes this in two ways. It raises the strobe exactly in the cycle where `out_valid` is high, and it holds the strobe high over many cycles with the data changing, so that a new set is taken on every legal edge and every strobe in between is dropped. A behavioural model in the bench decides on every edge whether a strobe is taken and when its result is due. That model is compared with `out_valid` and `out_sum` on every clock, so a stage that accepts one cycle early or late, or a lost or extra pulse, shows up at once.

// File: rtl/tps_pkg.sv
// Package tps_pkg
// Shared helpers for the tree prefix summer. Nodes use heap numbering:
// the root is 1 and the children of node n are 2n and 2n+1. Leaves occupy
// the indices N..2N-1.
package tps_pkg;

    // Tree level of heap node idx: the level-1 nodes sit just above the
    // leaves and the root sits at level `levels`.
    function automatic int node_level(input int idx, input int levels);
        int depth;
        int v;
        depth = 0;
        v = idx;
        while (v > 1) begin
            v = v >> 1;
            depth = depth + 1;
        end
        return levels - depth;
    endfunction

endpackage

// File: rtl/tps_ctrl.sv
// Module tps_ctrl
// Sequencer for the prefix tree. A single token walks a shift register,
// one bit per pipeline stage, and its position gives the load enable of
// each stage. A strobe is taken only while no token sits in the
// stages before the last one. A strobe that lands in the output cycle is
// therefore still taken.
// Assumes: STAGES >= 2.
module tps_ctrl #(
    parameter int STAGES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic [STAGES-1:0] stage_en,
    output logic              out_valid
);

    logic [STAGES-1:0] token_q;
    logic              busy;
    logic              take;

    assign busy      = |token_q[STAGES-2:0];
    assign take      = in_valid && !busy;
    assign stage_en  = {token_q[STAGES-2:0], take};
    assign out_valid = token_q[STAGES-1];

    // Advance the token one stage per cycle and inject a new token on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            token_q <= '0;
        end else begin
            token_q <= {token_q[STAGES-2:0], take};
        end
    end

    // R2: the result strobe lasts one cycle only.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R6: at most one set is ever in flight.
    a_r6_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(token_q));

endmodule

// File: rtl/tps_up_node.sv
// Module tps_up_node
// Internal tree node used in the upward sweep. When enabled, it registers
// the sum of its two child totals for its parent and keeps the left child
// total for the downward sweep.
// Assumes: W is wide enough for the full subtree sum.
module tps_up_node #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] left_in,
    input  logic [W-1:0] right_in,
    output logic [W-1:0] sum_q,
    output logic [W-1:0] left_q
);

    // Latch the subtree total and the left-child total on the stage enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q  <= '0;
            left_q <= '0;
        end else if (en) begin
            sum_q  <= left_in + right_in;
            left_q <= left_in;
        end
    end

endmodule

// File: rtl/tps_down_node.sv
// Module tps_down_node
// Register that holds the value a node receives from its parent during the
// downward sweep. For a left child the parent supplies zero as add_in.
// For a right child it supplies its kept left total.
// Assumes: the parent's kept total is stable while en is high.
module tps_down_node #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] p_in,
    input  logic [W-1:0] add_in,
    output logic [W-1:0] down_q
);

    // Load the value handed down by the parent on the stage enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_q <= '0;
        end else if (en) begin
            down_q <= p_in + add_in;
        end
    end

endmodule

// File: rtl/tps_leaf_out.sv
// Module tps_leaf_out
// Tree leaf. It captures its input lane when a set is taken and holds it
// through both sweeps. In the final stage it registers its running total:
// the value from its parent plus its own captured lane.
// Assumes: no new set is taken before out_en of the current set.
module tps_leaf_out #(
    parameter int IN_W = 8,
    parameter int W    = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic            out_en,
    input  logic [IN_W-1:0] x_in,
    input  logic [W-1:0]    p_in,
    input  logic [W-1:0]    add_in,
    output logic [W-1:0]    out_q
);

    logic [IN_W-1:0] held_q;

    // Hold the lane value for the whole trip through the tree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (cap_en) begin
            held_q <= x_in;
        end
    end

    // Form the lane result in the last stage and hold it until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (out_en) begin
            out_q <= p_in + add_in + W'(held_q);
        end
    end

endmodule

// File: rtl/tree_prefix_sum.sv
// Module tree_prefix_sum
// Inclusive running totals over N_LEAVES lanes, computed with a binary tree
// in two sweeps. Upward: one level per cycle, and each node keeps its
// left-child total. Downward: the root sends zero left and its kept total
// right, and each lower node sends (received) left and (received + kept)
// right, one level per cycle. The leaves then add their own lanes. The
// latency is 2*log2(N_LEAVES) edges. Only one set is in flight at a time.
// Assumes: N_LEAVES is a power of two and at least 4.
module tree_prefix_sum #(
    parameter  int N_LEAVES = 8,
    parameter  int IN_W     = 8,
    localparam int LEVELS   = $clog2(N_LEAVES),
    localparam int OUT_W    = IN_W + LEVELS,
    localparam int STAGES   = 2 * LEVELS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [N_LEAVES*IN_W-1:0]  in_data,
    output logic                      out_valid,
    output logic [N_LEAVES*OUT_W-1:0] out_sum
);

    logic [STAGES-1:0] stage_en;
    logic [OUT_W-1:0]  sum_v  [1:N_LEAVES-1];
    logic [OUT_W-1:0]  left_v [1:N_LEAVES-1];
    logic [OUT_W-1:0]  down_v [2:N_LEAVES-1];
    logic [OUT_W-1:0]  lane_q [N_LEAVES];

    tps_ctrl #(.STAGES(STAGES)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .stage_en  (stage_en),
        .out_valid (out_valid)
    );

    // Upward sweep: a level-k node loads in stage k-1.
    for (genvar j = 1; j < N_LEAVES; j++) begin : g_up
        localparam int LVL = tps_pkg::node_level(j, LEVELS);
        logic [OUT_W-1:0] l_child;
        logic [OUT_W-1:0] r_child;
        if (LVL == 1) begin : g_from_lanes
            assign l_child = OUT_W'(in_data[(2*j-N_LEAVES)*IN_W +: IN_W]);
            assign r_child = OUT_W'(in_data[(2*j+1-N_LEAVES)*IN_W +: IN_W]);
        end else begin : g_from_nodes
            assign l_child = sum_v[2*j];
            assign r_child = sum_v[2*j+1];
        end
        tps_up_node #(.W(OUT_W)) u_node (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (stage_en[LVL-1]),
            .left_in  (l_child),
            .right_in (r_child),
            .sum_q    (sum_v[j]),
            .left_q   (left_v[j])
        );
    end

    // Downward sweep: a level-k node receives its value in stage STAGES-1-k.
    for (genvar i = 2; i < N_LEAVES; i++) begin : g_down
        localparam int LVL = tps_pkg::node_level(i, LEVELS);
        localparam int PAR = i / 2;
        logic [OUT_W-1:0] p_par;
        logic [OUT_W-1:0] add_v;
        if (PAR == 1) begin : g_root_parent
            assign p_par = '0;
        end else begin : g_inner_parent
            assign p_par = down_v[PAR];
        end
        if (i % 2 == 1) begin : g_right
            assign add_v = left_v[PAR];
        end else begin : g_left
            assign add_v = '0;
        end
        tps_down_node #(.W(OUT_W)) u_node (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (stage_en[STAGES-1-LVL]),
            .p_in   (p_par),
            .add_in (add_v),
            .down_q (down_v[i])
        );
    end

    // Leaves: capture in stage 0 and form the result in the last stage.
    for (genvar k = 0; k < N_LEAVES; k++) begin : g_leaf
        localparam int PAR = (N_LEAVES + k) / 2;
        logic [OUT_W-1:0] add_v;
        if (k % 2 == 1) begin : g_right
            assign add_v = left_v[PAR];
        end else begin : g_left
            assign add_v = '0;
        end
        tps_leaf_out #(.IN_W(IN_W), .W(OUT_W)) u_leaf (
            .clk    (clk),
            .rst_n  (rst_n),
            .cap_en (stage_en[0]),
            .out_en (stage_en[STAGES-1]),
            .x_in   (in_data[k*IN_W +: IN_W]),
            .p_in   (down_v[PAR]),
            .add_in (add_v),
            .out_q  (lane_q[k])
        );
        assign out_sum[k*OUT_W +: OUT_W] = lane_q[k];
    end

    // R8: results change only together with the strobe.
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_sum));

    // R3: the top lane equals the total the root formed on the way up.
    a_r3_total: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lane_q[N_LEAVES-1] == sum_v[1]));

    // R4: the top lane never exceeds the largest possible total.
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(lane_q[N_LEAVES-1]) <= N_LEAVES * ((1 << IN_W) - 1)));

    // R3: running totals of unsigned lanes never decrease from lane to lane.
    for (genvar m = 0; m < N_LEAVES - 1; m++) begin : g_mono
        a_r3_monotone: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (lane_q[m+1] >= lane_q[m]));
    end

endmodule

// File: tb/test_tree_prefix_sum.sv
// Bench for tree_prefix_sum. A behavioural model decides which strobes are
// taken and when each result is due. It is compared with the outputs on
// every falling edge. Directed scenarios add named checks.
module test_tree_prefix_sum;

    localparam int N  = 8;
    localparam int IW = 8;
    localparam int LV = 3;
    localparam int OW = IW + LV;
    localparam int LAT = 2 * LV;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [N*IW-1:0] in_data = '0;
    logic            out_valid;
    logic [N*OW-1:0] out_sum;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tree_prefix_sum #(.N_LEAVES(N), .IN_W(IW)) i_tree_prefix_sum (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_sum   (out_sum)
    );

    task automatic check(input bit ok, input string req,
                         input logic [N*OW-1:0] act, input logic [N*OW-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [N*OW-1:0] prefix_of(input logic [N*IW-1:0] v);
        int run;
        logic [N*OW-1:0] r;
        run = 0;
        r = '0;
        for (int k = 0; k < N; k++) begin
            run = run + int'(v[k*IW +: IW]);
            r[k*OW +: OW] = OW'(run);
        end
        return r;
    endfunction

    // Behavioural model: edge counter, one pending set, due edge.
    int              cyc = 0;
    bit              m_pend = 1'b0;
    int              m_due = 0;
    bit              m_valid = 1'b0;
    logic [N*OW-1:0] m_pend_sum = '0;
    logic [N*OW-1:0] m_out = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 1'b0;
            m_valid = 1'b0;
            m_out = '0;
        end else begin
            if (in_valid && !m_pend) begin
                m_pend = 1'b1;
                m_due = cyc + LAT - 1;
                m_pend_sum = prefix_of(in_data);
            end
            m_valid = m_pend && (cyc == m_due);
            if (m_valid) begin
                m_out = m_pend_sum;
                m_pend = 1'b0;
            end
        end
        cyc++;
    end

    // Per-clock comparison against the model (R2, R3, R8).
    int pulses = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(out_valid == m_valid, "R2", N*OW'(out_valid), N*OW'(m_valid));
            check(out_sum == m_out, m_valid ? "R3" : "R8", out_sum, m_out);
            if (out_valid) pulses++;
        end
    end

    task automatic send(input logic [N*IW-1:0] v, output int at);
        in_valid = 1'b1;
        in_data = v;
        at = cyc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_pulse(output int at);
        at = -1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (out_valid) begin
                at = cyc;
                break;
            end
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int t_send;
        int t_out;
        int p0;
        logic [N*IW-1:0] v;
        logic [N*IW-1:0] a;
        logic [N*OW-1:0] e;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(out_valid == 1'b0 && out_sum == '0, "R1", out_sum, '0);

        // R5 and R2: the worked example and the latency
        for (int k = 0; k < N; k++) v[k*IW +: IW] = IW'(k + 1);
        send(v, t_send);
        wait_pulse(t_out);
        check(t_out - t_send == LAT, "R2", N*OW'(t_out - t_send), N*OW'(LAT));
        e = '0;
        e[0*OW +: OW] = 11'd1;  e[1*OW +: OW] = 11'd3;
        e[2*OW +: OW] = 11'd6;  e[3*OW +: OW] = 11'd10;
        e[4*OW +: OW] = 11'd15; e[5*OW +: OW] = 11'd21;
        e[6*OW +: OW] = 11'd28; e[7*OW +: OW] = 11'd36;
        check(out_sum == e, "R5", out_sum, e);
        repeat (4) @(negedge clk);

        // R4: all lanes at maximum
        v = '1;
        send(v, t_send);
        wait_pulse(t_out);
        check(out_sum[(N-1)*OW +: OW] == 11'd2040, "R4",
              N*OW'(out_sum[(N-1)*OW +: OW]), N*OW'(2040));
        for (int k = 0; k < N; k++) e[k*OW +: OW] = OW'(255 * (k + 1));
        check(out_sum == e, "R4", out_sum, e);
        repeat (3) @(negedge clk);

        // R3: assorted patterns
        for (int n = 0; n < 12; n++) begin
            v = {$urandom(), $urandom()};
            if (n == 0) v = 64'h0000_0000_0000_00FF;
            if (n == 1) v = 64'hFF00_0000_0000_0000;
            if (n == 2) v = '0;
            send(v, t_send);
            wait_pulse(t_out);
            check(out_sum == prefix_of(v), "R3", out_sum, prefix_of(v));
            repeat (n % 3) @(negedge clk);
        end

        // R6: a strobe while a set is in flight is dropped
        a = 64'h1122_3344_5566_7788;
        p0 = pulses;
        send(a, t_send);
        @(negedge clk);
        send(64'hFFFF_FFFF_FFFF_FFFF, t_send);
        @(negedge clk);
        send(64'h0102_0304_0506_0708, t_send);
        repeat (14) @(negedge clk);
        check(pulses - p0 == 1, "R6", N*OW'(pulses - p0), N*OW'(1));
        check(out_sum == prefix_of(a), "R6", out_sum, prefix_of(a));

        // R7: a strobe in the result cycle is taken; R8: result then holds
        send(64'h0807_0605_0403_0201, t_send);
        wait_pulse(t_out);
        v = 64'h9988_7766_5544_3322;
        send(v, t_send);
        wait_pulse(t_out);
        check(t_out - t_send == LAT, "R7", N*OW'(t_out - t_send), N*OW'(LAT));
        check(out_sum == prefix_of(v), "R7", out_sum, prefix_of(v));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_sum == prefix_of(v), "R8", out_sum, prefix_of(v));

        // R6 and R7: strobe held high with fresh data each cycle
        p0 = pulses;
        in_valid = 1'b1;
        for (int n = 0; n < 36; n++) begin
            in_data = {$urandom(), $urandom()};
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (10) @(negedge clk);
        check(pulses - p0 == 6, "R7", N*OW'(pulses - p0), N*OW'(6));

        finish_run();
    end

endmodule